// File: doc/BRIEF.md
# Supply Fault Threshold Detector

This block is the digital back end of one supervisory input channel of a power-sequencing controller. In supply mode it takes an 8-bit level code from an upstream converter. It compares the code against a programmable undervoltage limit and a programmable overvoltage limit. Once a limit has tripped, the flag holds across a programmable hysteresis band. The selected fault is then passed through a time-domain glitch filter. The filter removes short excursions and delays accepted changes by the programmed timeout.

The same channel can be used as a logic input instead. The pin level goes through the same glitch filter. The event output then carries either the filtered level or, in edge mode, a pulse of programmable width on a rising or a falling transition. All timing is counted on a 10 µs strobe that is derived elsewhere from the 100 kHz on-chip clock.

Top module: `supply_fault_detector`

## Requirements
- R1: While `rst_n` is low and on the first sampling after reset, `uv_flag`, `ov_flag` and `event_out` are 0.
- R2: On the clock edge after `level_code` is strictly below `uv_limit`, `uv_flag` becomes 1. On the clock edge after `level_code` is strictly above `ov_limit`, `ov_flag` becomes 1. A code equal to a limit does not trip that flag.
- R3: Once `uv_flag` is set, it clears only on the edge after `level_code` exceeds `uv_limit + hyst_code`. The sum is taken 9 bits wide.
- R4: Once `ov_flag` is set, it clears only on the edge after `level_code + hyst_code` is below `ov_limit`.
- R5: `fault_sel` picks the fault fed to the filter in supply mode (`analog_mode`=1): 2'b00 none, 2'b01 undervoltage, 2'b10 overvoltage, 2'b11 either. Both flags are reported at all times, whatever `fault_sel` holds.
- R6: With `filter_ticks`=0, the event follows the selected fault or the pin with no added delay.
- R7: With `filter_ticks`=N>0, a change of the raw signal that lasts fewer than N strobe periods never reaches the output. Each change of the raw signal restarts the count.
- R8: With `filter_ticks`=N>0, a change that lasts longer reaches the output on the N-th `tick` strobe after the raw signal settled, for both rising and falling changes.
- R9: In logic mode (`analog_mode`=0) with `edge_mode`=0, `event_out` is the filtered `logic_pin` level.
- R10: In logic mode with `edge_mode`=1, an edge of the filtered pin raises `event_out` on the next clock. A rising edge counts when `edge_rising`=1 and a falling edge counts when `edge_rising`=0. The pulse ends on the W-th strobe, where W is `pulse_ticks`. Edges of the other polarity give no pulse.
- R11: With `pulse_ticks`=0, an accepted edge gives a `event_out` pulse of exactly one clock.
- R12: `filter_ticks` and `pulse_ticks` values above 10 behave as 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe every 10 µs |
| analog_mode | input | 1 | 1 = supply comparison, 0 = logic input |
| level_code | input | 8 | Sampled supply level code |
| logic_pin | input | 1 | Synchronised logic input level |
| uv_limit | input | 8 | Undervoltage threshold code |
| ov_limit | input | 8 | Overvoltage threshold code |
| hyst_code | input | 5 | Hysteresis in code steps |
| fault_sel | input | 2 | Fault type selection |
| filter_ticks | input | 4 | Glitch filter timeout in strobes |
| edge_mode | input | 1 | Logic mode: 1 = edge pulse, 0 = level |
| edge_rising | input | 1 | Edge polarity: 1 rising, 0 falling |
| pulse_ticks | input | 4 | Edge pulse width in strobes |
| uv_flag | output | 1 | Undervoltage status |
| ov_flag | output | 1 | Overvoltage status |
| event_out | output | 1 | Filtered fault or logic event |

## Verification
A wrong hysteresis state shows up at `uv_flag` or `ov_flag` on the very next edge after a code inside the band. The flag either fails to hold or releases early. A corrupted filter candidate or counter shows up at `event_out`. The event then either fires for a short excursion or moves outside the one-strobe window that ends N strobes after the change. A stuck edge-pulse counter shows up as a pulse that is too long, or that does not end one clock after it starts when the width is zero. The directed scenarios sample just before and just after each of these windows.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
   typedef enum logic [1:0] {
      SEL_NONE   = 2'b00,
      SEL_UNDER  = 2'b01,
      SEL_OVER   = 2'b10,
      SEL_WINDOW = 2'b11
   } fault_sel_e;
endpackage

// File: rtl/sfd_limit_cmp.sv
module sfd_limit_cmp #(
   parameter int CODE_W  = 8,
   parameter int HYST_W  = 5,
   parameter bit IS_OVER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CODE_W-1:0] code,
   input  logic [CODE_W-1:0] limit,
   input  logic [HYST_W-1:0] hyst,
   output logic              flag
);
   localparam int SUM_W = CODE_W + 1;

   logic [SUM_W-1:0] code_x, limit_x, hyst_x;
   logic             trip, release_ok, flag_q;

   assign code_x  = SUM_W'(code);
   assign limit_x = SUM_W'(limit);
   assign hyst_x  = SUM_W'(hyst);

   generate
      if (HYST_W > CODE_W) begin : g_bad_width
         $error("sfd_limit_cmp: HYST_W must not exceed CODE_W");
      end
      if (IS_OVER) begin : g_over
         assign trip       = code_x > limit_x;
         assign release_ok = (code_x + hyst_x) < limit_x;
      end else begin : g_under
         assign trip       = code_x < limit_x;
         assign release_ok = code_x > (limit_x + hyst_x);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)      flag_q <= 1'b0;
      else if (flag_q) flag_q <= !release_ok;
      else             flag_q <= trip;
   end

   assign flag = flag_q;

   generate
      if (IS_OVER) begin : g_chk_over
         assert_ov_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag && code > limit) |=> flag);
         assert_ov_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (flag && ({1'b0, code} + {4'b0, hyst}) >= {1'b0, limit}) |=> flag);
      end else begin : g_chk_under
         assert_uv_trip_R2: assert property (@(posedge clk) disable iff (!rst_n)
            (!flag && code < limit) |=> flag);
         assert_uv_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
            (flag && {1'b0, code} <= ({1'b0, limit} + {4'b0, hyst})) |=> flag);
      end
   endgenerate
endmodule

// File: rtl/sfd_glitch_filter.sv
module sfd_glitch_filter #(
   parameter int TIME_W    = 4,
   parameter int MAX_TICKS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic [TIME_W-1:0] setting,
   input  logic              raw,
   output logic              filt
);
   localparam logic [TIME_W-1:0] MAX_V = TIME_W'(MAX_TICKS);

   logic [TIME_W-1:0] eff, cnt_q;
   logic              cand_q, out_q;

   generate
      if (MAX_TICKS >= (1 << TIME_W) || MAX_TICKS < 1) begin : g_bad_max
         $error("sfd_glitch_filter: MAX_TICKS does not fit TIME_W");
      end
   endgenerate

   assign eff = (setting > MAX_V) ? MAX_V : setting;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cand_q <= 1'b0;
         out_q  <= 1'b0;
         cnt_q  <= '0;
      end else if (eff == '0) begin
         cand_q <= raw;
         out_q  <= raw;
         cnt_q  <= '0;
      end else if (raw != cand_q) begin
         cand_q <= raw;
         cnt_q  <= '0;
      end else if (tick && (cand_q != out_q)) begin
         if (cnt_q >= eff - 1'b1) begin
            out_q <= cand_q;
            cnt_q <= '0;
         end else begin
            cnt_q <= cnt_q + 1'b1;
         end
      end
   end

   assign filt = (eff == '0) ? raw : out_q;

   assert_filter_on_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(eff) != '0 && !$stable(out_q)) |-> $past(tick));
   assert_filter_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q < eff) || (cnt_q == '0));
endmodule

// File: rtl/sfd_edge_pulse.sv
module sfd_edge_pulse #(
   parameter int TIME_W    = 4,
   parameter int MAX_TICKS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              rising,
   input  logic [TIME_W-1:0] width,
   input  logic              sig,
   output logic              pulse
);
   localparam logic [TIME_W-1:0] MAX_V = TIME_W'(MAX_TICKS);

   logic [TIME_W-1:0] eff, pcnt_q;
   logic              prev_q, pulse_q, edge_hit;

   assign eff      = (width > MAX_V) ? MAX_V : width;
   assign edge_hit = rising ? (sig && !prev_q) : (!sig && prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_q  <= 1'b0;
         pulse_q <= 1'b0;
         pcnt_q  <= '0;
      end else begin
         prev_q <= sig;
         if (edge_hit) begin
            pulse_q <= 1'b1;
            pcnt_q  <= '0;
         end else if (pulse_q) begin
            if (eff == '0) begin
               pulse_q <= 1'b0;
            end else if (tick) begin
               if (pcnt_q >= eff - 1'b1) begin
                  pulse_q <= 1'b0;
                  pcnt_q  <= '0;
               end else begin
                  pcnt_q <= pcnt_q + 1'b1;
               end
            end
         end
      end
   end

   assign pulse = pulse_q;

   assert_edge_starts_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
      edge_hit |=> pulse);
   assert_zero_width_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse && eff == '0 && !edge_hit) |=> !pulse);
endmodule

// File: rtl/supply_fault_detector.sv
module supply_fault_detector #(
   parameter int CODE_W    = 8,
   parameter int HYST_W    = 5,
   parameter int TIME_W    = 4,
   parameter int MAX_TICKS = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              analog_mode,
   input  logic [CODE_W-1:0] level_code,
   input  logic              logic_pin,
   input  logic [CODE_W-1:0] uv_limit,
   input  logic [CODE_W-1:0] ov_limit,
   input  logic [HYST_W-1:0] hyst_code,
   input  logic [1:0]        fault_sel,
   input  logic [TIME_W-1:0] filter_ticks,
   input  logic              edge_mode,
   input  logic              edge_rising,
   input  logic [TIME_W-1:0] pulse_ticks,
   output logic              uv_flag,
   output logic              ov_flag,
   output logic              event_out
);
   import sfd_pkg::*;

   logic       uv_s, ov_s, sel_fault, raw_sig, filt_sig, edge_pulse;
   fault_sel_e sel;

   sfd_limit_cmp #(.CODE_W(CODE_W), .HYST_W(HYST_W), .IS_OVER(1'b0)) i_under (
      .clk(clk), .rst_n(rst_n), .code(level_code), .limit(uv_limit),
      .hyst(hyst_code), .flag(uv_s));

   sfd_limit_cmp #(.CODE_W(CODE_W), .HYST_W(HYST_W), .IS_OVER(1'b1)) i_over (
      .clk(clk), .rst_n(rst_n), .code(level_code), .limit(ov_limit),
      .hyst(hyst_code), .flag(ov_s));

   assign sel = fault_sel_e'(fault_sel);

   always_comb begin
      unique case (sel)
         SEL_UNDER:  sel_fault = uv_s;
         SEL_OVER:   sel_fault = ov_s;
         SEL_WINDOW: sel_fault = uv_s || ov_s;
         default:    sel_fault = 1'b0;
      endcase
   end

   assign raw_sig = analog_mode ? sel_fault : logic_pin;

   sfd_glitch_filter #(.TIME_W(TIME_W), .MAX_TICKS(MAX_TICKS)) i_filter (
      .clk(clk), .rst_n(rst_n), .tick(tick), .setting(filter_ticks),
      .raw(raw_sig), .filt(filt_sig));

   sfd_edge_pulse #(.TIME_W(TIME_W), .MAX_TICKS(MAX_TICKS)) i_edge (
      .clk(clk), .rst_n(rst_n), .tick(tick), .rising(edge_rising),
      .width(pulse_ticks), .sig(filt_sig), .pulse(edge_pulse));

   assign uv_flag   = uv_s;
   assign ov_flag   = ov_s;
   assign event_out = (!analog_mode && edge_mode) ? edge_pulse : filt_sig;

   assert_sel_none_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (analog_mode && fault_sel == 2'b00 && filter_ticks == '0) |-> !event_out);
   assert_level_pass_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!analog_mode && !edge_mode && filter_ticks == '0) |-> (event_out == logic_pin));
endmodule

// File: tb/test_supply_fault_detector.sv
module test_supply_fault_detector;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       analog_mode = 1'b1;
   logic [7:0] level_code = 8'd150;
   logic       logic_pin = 1'b0;
   logic [7:0] uv_limit = 8'd100;
   logic [7:0] ov_limit = 8'd200;
   logic [4:0] hyst_code = 5'd4;
   logic [1:0] fault_sel = 2'b11;
   logic [3:0] filter_ticks = 4'd0;
   logic       edge_mode = 1'b0;
   logic       edge_rising = 1'b1;
   logic [3:0] pulse_ticks = 4'd0;
   logic       uv_flag, ov_flag, event_out;

   int n_checks = 0;
   int n_fail   = 0;
   int tcnt     = 0;
   localparam int TDIV = 8;

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      tcnt <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
      tick <= (tcnt == TDIV - 1);
   end

   supply_fault_detector i_supply_fault_detector (
      .clk(clk), .rst_n(rst_n), .tick(tick), .analog_mode(analog_mode),
      .level_code(level_code), .logic_pin(logic_pin), .uv_limit(uv_limit),
      .ov_limit(ov_limit), .hyst_code(hyst_code), .fault_sel(fault_sel),
      .filter_ticks(filter_ticks), .edge_mode(edge_mode), .edge_rising(edge_rising),
      .pulse_ticks(pulse_ticks), .uv_flag(uv_flag), .ov_flag(ov_flag),
      .event_out(event_out));

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic quiet(input string req, input int n);
      logic seen = 1'b0;
      for (int i = 0; i < n; i++) begin
         step(1);
         if (event_out) seen = 1'b1;
      end
      chk(req, seen, 1'b0);
   endtask

   task automatic t_reset;
      chk("R1 uv reset", uv_flag, 1'b0);
      chk("R1 ov reset", ov_flag, 1'b0);
      chk("R1 event reset", event_out, 1'b0);
   endtask

   task automatic t_under;
      level_code = 8'd100; step(1); chk("R2 uv equal no trip", uv_flag, 1'b0);
      level_code = 8'd99;  step(1); chk("R2 uv trip", uv_flag, 1'b1);
      level_code = 8'd104; step(1); chk("R3 uv hold in band", uv_flag, 1'b1);
      level_code = 8'd105; step(1); chk("R3 uv release", uv_flag, 1'b0);
      level_code = 8'd150; step(1);
   endtask

   task automatic t_over;
      level_code = 8'd200; step(1); chk("R2 ov equal no trip", ov_flag, 1'b0);
      level_code = 8'd201; step(1); chk("R2 ov trip", ov_flag, 1'b1);
      level_code = 8'd196; step(1); chk("R4 ov hold in band", ov_flag, 1'b1);
      level_code = 8'd195; step(1); chk("R4 ov release", ov_flag, 1'b0);
      level_code = 8'd150; step(1);
   endtask

   task automatic t_select;
      fault_sel = 2'b00; level_code = 8'd50; step(1);
      chk("R5 none sel flag still set", uv_flag, 1'b1);
      chk("R5 none sel no event", event_out, 1'b0);
      fault_sel = 2'b01; step(1); chk("R5 uv sel event", event_out, 1'b1);
      level_code = 8'd250; step(1); chk("R5 uv sel ignores ov", event_out, 1'b0);
      fault_sel = 2'b10; step(1); chk("R6 ov sel event no delay", event_out, 1'b1);
      fault_sel = 2'b11; level_code = 8'd50; step(1); chk("R5 window low", event_out, 1'b1);
      level_code = 8'd150; step(1); chk("R5 window inside", event_out, 1'b0);
   endtask

   task automatic t_filter;
      filter_ticks = 4'd3; step(20);
      level_code = 8'd50; step(16); level_code = 8'd150;
      quiet("R7 short pulse suppressed", 60);
      level_code = 8'd50;
      step(2 + 2 * TDIV); chk("R8 rise not early", event_out, 1'b0);
      step(TDIV);         chk("R8 rise after timeout", event_out, 1'b1);
      level_code = 8'd150;
      step(2 + 2 * TDIV); chk("R8 fall not early", event_out, 1'b1);
      step(TDIV);         chk("R8 fall after timeout", event_out, 1'b0);
   endtask

   task automatic t_clamp;
      filter_ticks = 4'd15; step(20);
      level_code = 8'd50;
      step(2 + 9 * TDIV); chk("R12 clamped not early", event_out, 1'b0);
      step(TDIV);         chk("R12 clamped at ten", event_out, 1'b1);
      level_code = 8'd150; step(12 * TDIV);
      filter_ticks = 4'd0;
   endtask

   task automatic t_level;
      analog_mode = 1'b0; edge_mode = 1'b0; logic_pin = 1'b0; step(2);
      logic_pin = 1'b1; step(1); chk("R9 level high", event_out, 1'b1);
      logic_pin = 1'b0; step(1); chk("R9 level low", event_out, 1'b0);
   endtask

   task automatic t_edge;
      edge_mode = 1'b1; edge_rising = 1'b1; pulse_ticks = 4'd2; step(30);
      logic_pin = 1'b1; step(1); chk("R10 rising starts", event_out, 1'b1);
      step(TDIV);     chk("R10 pulse still high", event_out, 1'b1);
      step(TDIV);     chk("R10 pulse ended", event_out, 1'b0);
      logic_pin = 1'b0; quiet("R10 falling ignored when rising", 30);
      edge_rising = 1'b0; step(2);
      logic_pin = 1'b1; quiet("R10 rising ignored when falling", 30);
      logic_pin = 1'b0; step(1); chk("R10 falling starts", event_out, 1'b1);
      step(3 * TDIV); chk("R10 falling pulse ended", event_out, 1'b0);
   endtask

   task automatic t_zero_width;
      edge_rising = 1'b1; pulse_ticks = 4'd0; step(4);
      logic_pin = 1'b1; step(1); chk("R11 one cycle high", event_out, 1'b1);
      step(1); chk("R11 one cycle then low", event_out, 1'b0);
      logic_pin = 1'b0; step(4);
   endtask

   initial begin
      step(5);
      t_reset;
      rst_n = 1'b1;
      step(1);
      t_reset;
      t_under;
      t_over;
      t_select;
      t_filter;
      t_clamp;
      t_level;
      t_edge;
      t_zero_width;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
   end
endmodule